// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns parallel audio sample pairs into a three-wire serial stream: a word-select line, a serial data line, and an underflow pulse that warns of a starved frame. It runs on the system clock and moves one bit position per cycle in which the bit-clock enable `bclk_en` is high. Each frame has two slots of `SLOT_W` bit positions each. At the start of every frame, the block takes one left/right sample pair through a valid/ready handshake.

The frame format is set at run time. Four controls select it:

- the word-select shape: a level for the whole slot, or a one-bit frame pulse;
- a one-bit data delay after the word-select edge;
- the slot order;
- left or right justification of the sample inside its slot.

Together these give the common two-channel, left-justified and short/long frame-sync PCM layouts from one engine. A channel mode mutes single slots in stereo, or places one mono sample into one slot or both. A side output reports which sample-storage packing an upstream buffer should use for the current width and mono setting.

The configuration is expected to change only while `run` is low.

Top module: `audio_ser_tx`

## Requirements
- R1: With `cfg_msb_shift`=1, every data bit appears on `sd` one bit position later than with `cfg_msb_shift`=0, so the slot MSB follows the word-select edge by one bit clock. With `cfg_msb_shift`=0, the MSB shares the bit position of the edge.
- R2: With `cfg_short_sync`=0, `ws` is 1 for every bit position of the right-channel slot and 0 for every bit position of the left-channel slot.
- R3: With `cfg_short_sync`=1, `ws` is 1 only for the first bit position of each frame, so it lasts exactly one bit clock.
- R4: `cfg_right_first`=1 places the right slot first in the frame. `cfg_right_first`=0 places the left slot first.
- R5: In stereo (`cfg_mono`=0), `cfg_chan_mode` value 1 sends only the right slot and value 2 sends only the left slot. Any other value sends both slots. A muted slot carries zeros, and `ws` behaves as usual.
- R6: In mono (`cfg_mono`=1), only `smp_left` is used and `smp_right` is ignored. Mode 3 sends the sample in the right slot only, mode 4 sends it in the left slot only, and any other mode sends it in both slots.
- R7: `cfg_bits` (1..SLOT_W) data bits are sent MSB first. With `cfg_msb_right`=0, the bits start at the slot's first position and zeros follow. With `cfg_msb_right`=1, SLOT_W-`cfg_bits` zeros come first and the LSB lands on the slot's last position.
- R8: `fifo_mode` equals 2 when `cfg_bits` is greater than 16 and 0 otherwise, plus 1 when `cfg_mono` is set.
- R9: With `stop_on_empty`=1, a frame start with `smp_valid`=0 halts the output. `ws` and the undelayed data go to 0 and the frame position stays at the start until a sample arrives.
- R10: With `stop_on_empty`=0, a frame start with `smp_valid`=0 raises `underflow` for exactly one clock cycle. The frame is then sent with zero data and normal `ws` timing.
- R11: `smp_ready` is 1 only when `run` and `bclk_en` are high and the frame position is at its start. A sample pair is consumed only at that point.
- R12: After reset, and in any cycle following one with `run`=0, `ws`, `sd` and `underflow` are 0 and the next frame starts from its first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle strobe that advances one bit position |
| run | input | 1 | Transmitter enable; low clears the frame position and outputs |
| stop_on_empty | input | 1 | Halt instead of sending zeros when no sample is ready |
| cfg_bits | input | $clog2(SLOT_W+1) | Number of data bits per sample |
| cfg_short_sync | input | 1 | One-bit frame pulse instead of a slot-long level |
| cfg_msb_shift | input | 1 | Delay data by one bit position after the ws edge |
| cfg_right_first | input | 1 | Send the right slot first |
| cfg_msb_right | input | 1 | Right-justify data in its slot |
| cfg_mono | input | 1 | Single sample taken from smp_left |
| cfg_chan_mode | input | 3 | Slot selection code |
| smp_valid | input | 1 | Sample pair available |
| smp_ready | output | 1 | Sample pair consumed this cycle when valid |
| smp_left | input | SLOT_W | Left (or mono) sample, LSB aligned |
| smp_right | input | SLOT_W | Right sample, LSB aligned |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse on a starved frame start |
| fifo_mode | output | 2 | Packing code for the sample store |

## Verification
The bench sweeps every combination of the format bits, the mono flag and channel modes 0 to 4 at widths 5, 16 and 20 in a 20-bit slot. It also stalls the bit-clock enable irregularly, so that the frame position must advance only on strobes. A design that lost the one-bit delay across the frame boundary would corrupt the last bit of the second slot. Swapped slot order or an inverted `ws` level would flip whole slots. Wrong justification would shift samples by the padding width, and reading `smp_right` in mono would show up as foreign data. Directed runs starve the transmitter in both empty-handling modes. A design that kept clocking when told to stop, stretched the underflow pulse, or accepted samples mid-frame would disagree with the bench's expected stream.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;

    localparam int unsigned PACKED_LIMIT = 16;

    typedef struct packed {
        logic       short_sync;
        logic       msb_shift;
        logic       right_first;
        logic       msb_right;
        logic       mono;
        logic [2:0] chan_mode;
    } ser_fmt_t;

    typedef enum logic [2:0] {
        CM_BOTH       = 3'd0,
        CM_RIGHT_ONLY = 3'd1,
        CM_LEFT_ONLY  = 3'd2,
        CM_MONO_RIGHT = 3'd3,
        CM_MONO_LEFT  = 3'd4
    } chan_mode_e;

    typedef enum logic [1:0] {
        FM_NARROW_STEREO = 2'd0,
        FM_NARROW_MONO   = 2'd1,
        FM_WIDE_STEREO   = 2'd2,
        FM_WIDE_MONO     = 2'd3
    } fifo_mode_e;

    // Whether a slot carries data for the given format.
    function automatic logic slot_live(ser_fmt_t f, logic is_right);
        logic r;
        r = 1'b1;
        if (!f.mono) begin
            if (f.chan_mode == CM_RIGHT_ONLY)      r = is_right;
            else if (f.chan_mode == CM_LEFT_ONLY)  r = !is_right;
        end else begin
            if (f.chan_mode == CM_MONO_RIGHT)      r = is_right;
            else if (f.chan_mode == CM_MONO_LEFT)  r = !is_right;
        end
        return r;
    endfunction

    function automatic fifo_mode_e fifo_mode_of(int unsigned bits, logic mono);
        return fifo_mode_e'({(bits > PACKED_LIMIT), mono});
    endfunction

endpackage

// File: rtl/audio_ser_tx_seq.sv
module audio_ser_tx_seq #(
    parameter int SLOT_W = 32,
    parameter int POS_W  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_en,
    input  logic             run,
    input  logic             stop_on_empty,
    input  logic             smp_valid,
    output logic             smp_ready,
    output logic [POS_W-1:0] pos,
    output logic             frame_new,
    output logic             take,
    output logic             halt,
    output logic             underflow
);
    localparam int FRAME_LEN = 2 * SLOT_W;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos_q;
    logic             uf_q;
    logic             tick, at_start, emit;

    always_comb begin
        tick      = bclk_en & run;
        at_start  = (pos_q == '0);
        halt      = tick & at_start & !smp_valid & stop_on_empty;
        emit      = tick & !halt;
        frame_new = emit & at_start;
        take      = frame_new & smp_valid;
        smp_ready = run & bclk_en & at_start;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q <= '0;
        end else if (emit) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) uf_q <= 1'b0;
        else     uf_q <= frame_new & !smp_valid;
    end

    assign pos       = pos_q;
    assign underflow = uf_q;

    assert_underflow_single_R10: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !underflow);

    assert_accept_advances_R11: assert property (@(posedge clk) disable iff (rst)
        (smp_ready && smp_valid) |=> (pos_q == POS_W'(1)));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst)
        halt |=> (pos_q == '0));

    assert_pos_range: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

endmodule

// File: rtl/audio_ser_tx_slot.sv
module audio_ser_tx_slot
    import audio_ser_tx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int POS_W  = 6,
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_new,
    input  logic              take,
    input  logic [POS_W-1:0]  pos,
    input  ser_fmt_t          fmt,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [SLOT_W-1:0] smp_left,
    input  logic [SLOT_W-1:0] smp_right,
    output logic              ws_n,
    output logic              raw_n
);
    localparam int unsigned SW_U = SLOT_W;

    logic [SLOT_W-1:0] held_l, held_r, eff_l, eff_r, src, shifted;
    logic              slot_b, is_right, live, data_bit;
    logic [POS_W-1:0]  idx;
    logic [31:0]       nb, idx_i, shamt;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_l <= '0;
            held_r <= '0;
        end else if (frame_new) begin
            held_l <= take ? smp_left  : '0;
            held_r <= take ? smp_right : '0;
        end
    end

    always_comb begin
        eff_l    = frame_new ? (take ? smp_left  : '0) : held_l;
        eff_r    = frame_new ? (take ? smp_right : '0) : held_r;
        slot_b   = (32'(pos) >= SW_U);
        idx      = slot_b ? (pos - POS_W'(SLOT_W)) : pos;
        is_right = fmt.right_first ^ slot_b;
        src      = (fmt.mono || !is_right) ? eff_l : eff_r;
        nb       = (32'(cfg_bits) > SW_U) ? SW_U : 32'(cfg_bits);
        idx_i    = 32'(idx);
        if (!fmt.msb_right) begin
            live  = (idx_i < nb);
            shamt = nb - 32'd1 - idx_i;
        end else begin
            live  = (idx_i >= (SW_U - nb));
            shamt = SW_U - 32'd1 - idx_i;
        end
        shifted  = src >> shamt;
        data_bit = live & shifted[0];
        raw_n    = slot_live(fmt, is_right) & data_bit;
        ws_n     = fmt.short_sync ? (pos == '0) : is_right;
    end

    assert_muted_left_R5: assert property (@(posedge clk) disable iff (rst)
        (!fmt.mono && fmt.chan_mode == CM_RIGHT_ONLY && !is_right) |-> !raw_n);

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (fmt.msb_right && (idx_i < (SW_U - nb))) |-> !raw_n);

    assert_long_ws_R2: assert property (@(posedge clk) disable iff (rst)
        (!fmt.short_sync && slot_b) |-> (ws_n == !fmt.right_first));

endmodule

// File: rtl/audio_ser_tx_out.sv
module audio_ser_tx_out (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic halt,
    input  logic short_sync,
    input  logic msb_shift,
    input  logic ws_n,
    input  logic raw_n,
    output logic ws,
    output logic sd
);
    logic ws_q, raw_q, raw_d1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ws_q   <= 1'b0;
            raw_q  <= 1'b0;
            raw_d1 <= 1'b0;
        end else if (tick) begin
            ws_q   <= halt ? 1'b0 : ws_n;
            raw_q  <= halt ? 1'b0 : raw_n;
            raw_d1 <= raw_q;
        end
    end

    assign ws = ws_q;
    assign sd = msb_shift ? raw_d1 : raw_q;

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!ws && !sd));

    assert_short_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && short_sync && ws_q) |=> !ws_q);

    assert_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (run && tick && msb_shift) |=> (sd == $past(raw_q)));

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_ser_tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bclk_en,
    input  logic                         run,
    input  logic                         stop_on_empty,
    input  logic [$clog2(SLOT_W+1)-1:0]  cfg_bits,
    input  logic                         cfg_short_sync,
    input  logic                         cfg_msb_shift,
    input  logic                         cfg_right_first,
    input  logic                         cfg_msb_right,
    input  logic                         cfg_mono,
    input  logic [2:0]                   cfg_chan_mode,
    input  logic                         smp_valid,
    output logic                         smp_ready,
    input  logic [SLOT_W-1:0]            smp_left,
    input  logic [SLOT_W-1:0]            smp_right,
    output logic                         ws,
    output logic                         sd,
    output logic                         underflow,
    output logic [1:0]                   fifo_mode
);
    localparam int BITS_W = $clog2(SLOT_W + 1);
    localparam int POS_W  = $clog2(2 * SLOT_W);

    ser_fmt_t         fmt;
    logic [POS_W-1:0] pos;
    logic             frame_new, take, halt, tick, ws_n, raw_n;

    always_comb begin
        fmt.short_sync  = cfg_short_sync;
        fmt.msb_shift   = cfg_msb_shift;
        fmt.right_first = cfg_right_first;
        fmt.msb_right   = cfg_msb_right;
        fmt.mono        = cfg_mono;
        fmt.chan_mode   = cfg_chan_mode;
        tick            = bclk_en & run;
        fifo_mode       = fifo_mode_of(32'(cfg_bits), cfg_mono);
    end

    audio_ser_tx_seq #(.SLOT_W(SLOT_W), .POS_W(POS_W)) seq_i (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .run(run),
        .stop_on_empty(stop_on_empty), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .pos(pos), .frame_new(frame_new),
        .take(take), .halt(halt), .underflow(underflow)
    );

    audio_ser_tx_slot #(.SLOT_W(SLOT_W), .POS_W(POS_W), .BITS_W(BITS_W)) slot_i (
        .clk(clk), .rst(rst), .frame_new(frame_new), .take(take), .pos(pos),
        .fmt(fmt), .cfg_bits(cfg_bits), .smp_left(smp_left),
        .smp_right(smp_right), .ws_n(ws_n), .raw_n(raw_n)
    );

    audio_ser_tx_out out_i (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .halt(halt),
        .short_sync(cfg_short_sync), .msb_shift(cfg_msb_shift),
        .ws_n(ws_n), .raw_n(raw_n), .ws(ws), .sd(sd)
    );

endmodule

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb_top;
    localparam int  SW = 20;
    localparam int  BW = $clog2(SW + 1);
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic rst, bclk_en, run, stop_on_empty, smp_valid, smp_ready;
    logic [BW-1:0] cfg_bits;
    logic cfg_short_sync, cfg_msb_shift, cfg_right_first, cfg_msb_right, cfg_mono;
    logic [2:0] cfg_chan_mode;
    logic [SW-1:0] smp_left, smp_right;
    logic ws, sd, underflow;
    logic [1:0] fifo_mode;

    audio_ser_tx #(.SLOT_W(SW)) dut_i (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .run(run),
        .stop_on_empty(stop_on_empty), .cfg_bits(cfg_bits),
        .cfg_short_sync(cfg_short_sync), .cfg_msb_shift(cfg_msb_shift),
        .cfg_right_first(cfg_right_first), .cfg_msb_right(cfg_msb_right),
        .cfg_mono(cfg_mono), .cfg_chan_mode(cfg_chan_mode),
        .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right),
        .ws(ws), .sd(sd), .underflow(underflow), .fifo_mode(fifo_mode)
    );

    int checks = 0;
    int fails  = 0;
    string dreq = "R12";
    int m_pos = 0;
    logic [SW-1:0] m_l, m_r;
    logic m_ws = 0, m_raw = 0, m_prev = 0, m_uf = 0;
    logic [31:0] rnd = 32'h1234_5679;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] next_rand();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
        return rnd[SW-1:0];
    endfunction

    function automatic logic exp_right(int p);
        return (p < SW) ? cfg_right_first : !cfg_right_first;
    endfunction

    function automatic logic exp_bit(int p);
        logic right, on;
        logic [SW-1:0] s, mask, v, word;
        int nbits, idx;
        right = exp_right(p);
        idx   = p % SW;
        nbits = int'(cfg_bits);
        if (cfg_mono) on = (cfg_chan_mode == 3) ? right : (cfg_chan_mode == 4) ? !right : 1'b1;
        else          on = (cfg_chan_mode == 1) ? right : (cfg_chan_mode == 2) ? !right : 1'b1;
        s    = (cfg_mono || !right) ? m_l : m_r;
        mask = (nbits >= SW) ? '1 : ((SW'(1) << nbits) - SW'(1));
        v    = s & mask;
        word = cfg_msb_right ? v : (v << (SW - nbits));
        return on & word[SW-1-idx];
    endfunction

    task automatic model_step();
        if (m_pos == 0) begin
            if (smp_valid) begin
                m_l = smp_left;
                m_r = smp_right;
                smp_left  = next_rand();
                smp_right = next_rand();
            end else if (stop_on_empty) begin
                m_prev = m_raw;
                m_raw  = 1'b0;
                m_ws   = 1'b0;
                return;
            end else begin
                m_l  = '0;
                m_r  = '0;
                m_uf = 1'b1;
            end
        end
        m_prev = m_raw;
        m_raw  = exp_bit(m_pos);
        m_ws   = cfg_short_sync ? (m_pos == 0) : exp_right(m_pos);
        m_pos  = (m_pos + 1) % (2 * SW);
    endtask

    // Called at a falling edge; drives one rising edge and checks after it.
    task automatic cyc(logic en);
        bclk_en = en;
        @(posedge clk);
        #1;
        m_uf = 1'b0;
        if (!run) begin
            m_pos = 0; m_raw = 0; m_ws = 0; m_prev = 0;
        end else if (en) begin
            model_step();
        end
        @(negedge clk);
        check(dreq, "ws", 32'(ws), 32'(m_ws));
        check(dreq, "sd", 32'(sd), 32'(cfg_msb_shift ? m_prev : m_raw));
        check("R10", "underflow", 32'(underflow), 32'(m_uf));
    endtask

    task automatic run_ticks(int n);
        int c = 0;
        int done = 0;
        while (done < n) begin
            logic en = ((c % 4) != 3);
            cyc(en);
            if (en) done++;
            c++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int widths[3] = '{5, 16, 20};
        rst = 1; bclk_en = 0; run = 0; stop_on_empty = 0; smp_valid = 0;
        cfg_bits = BW'(16); cfg_short_sync = 0; cfg_msb_shift = 1; cfg_right_first = 0;
        cfg_msb_right = 0; cfg_mono = 0; cfg_chan_mode = 3'd0;
        smp_left = next_rand(); smp_right = next_rand();
        m_l = '0; m_r = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R12", "reset ws", 32'(ws), 0);
        check("R12", "reset sd", 32'(sd), 0);
        check("R12", "reset underflow", 32'(underflow), 0);
        check("R12", "reset ready", 32'(smp_ready), 0);

        // R11: ready only with strobe at frame start
        run = 1; stop_on_empty = 1; smp_valid = 0; bclk_en = 0;
        #1 check("R11", "ready without strobe", 32'(smp_ready), 0);
        bclk_en = 1;
        #1 check("R11", "ready at frame start", 32'(smp_ready), 1);
        // R9: halted while empty
        dreq = "R9";
        repeat (5) cyc(1'b1);
        check("R9", "halted ws", 32'(ws), 0);
        check("R9", "halted sd", 32'(sd), 0);
        smp_valid = 1;
        cyc(1'b1);
        bclk_en = 1;
        #1 check("R11", "ready mid-frame", 32'(smp_ready), 0);
        bclk_en = 0;
        run_ticks(2 * SW);
        smp_valid = 0;
        run_ticks(2 * SW + 6);

        // R10: starved frames keep clocking
        dreq = "R10";
        stop_on_empty = 0;
        run_ticks(4 * SW + 3);

        // R12: stop mid-frame
        smp_valid = 1;
        run_ticks(SW + 3);
        dreq = "R12";
        run = 0;
        repeat (3) cyc(1'b1);

        // R8: packing code
        for (int w = 1; w <= SW; w++) begin
            for (int m = 0; m < 2; m++) begin
                cfg_bits = BW'(w);
                cfg_mono = m[0];
                #1 check("R8", "fifo_mode", 32'(fifo_mode), 32'(((w > 16) ? 2 : 0) + m));
            end
        end

        // Sweep of formats, orders, justification and slot modes
        dreq = "R1/R2/R3/R4/R5/R6/R7";
        stop_on_empty = 0;
        smp_valid = 1;
        foreach (widths[wi]) begin
            for (int fv = 0; fv < 32; fv++) begin
                for (int cm = 0; cm < 5; cm++) begin
                    cfg_bits        = BW'(widths[wi]);
                    cfg_short_sync  = fv[0];
                    cfg_msb_shift   = fv[1];
                    cfg_right_first = fv[2];
                    cfg_msb_right   = fv[3];
                    cfg_mono        = fv[4];
                    cfg_chan_mode   = 3'(cm);
                    run = 1;
                    run_ticks(4 * SW + 2);
                    run = 0;
                    cyc(1'b0);
                    cyc(1'b0);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule